// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Event Status

This block sits between a 32-bit register bus and a serial audio engine. It holds one queue of outgoing samples, filled by the bus and drained by the engine, and one queue of incoming samples, filled by the engine and drained by the bus. Each queue raises a DMA request from its fill level against a programmable threshold. Abnormal traffic, meaning a push into a full queue, a pull from an empty one, or a fault signalled from outside, is latched into an eight-bit event register. That register is split into a transmit group and a receive group.

Event bits are cleared by writing ones. A mask register decides which of them drive the interrupt line. A read-only level word shows how full each queue is. Writing the configuration word with its global enable at zero returns the configuration and the mask to their reset values.

Registers are selected by a word index on `regAddr`. Bus reads return data in the same cycle as `regRdEn`. A read of the receive data port removes the head entry at the clock edge.

Top module: `afifo_top`

## Requirements
- R1: Each queue holds DEPTH (32) words of 32 bits and returns them in the order they were written. Transmit words are written at register index 4 and appear on `txSample`; receive words enter on `rxSample` and are read at register index 5.
- R2: A bus write to index 4 while the transmit queue is full is discarded, and sets event bit 2.
- R3: An engine pull (`txPull`) from an empty transmit queue shows zero on `txSample` and sets event bit 1.
- R4: An engine push (`rxPush`) into a full receive queue is discarded, and sets event bit 6.
- R5: A bus read of index 5 while the receive queue is empty returns zero and sets event bit 5.
- R6: The configuration word (index 0) has these fields:
  - global enable at bit 31, DMA enable at bit 30, transmit enable at bit 24, receive enable at bit 20;
  - receive threshold at bits 15:12 and transmit threshold at bits 7:4, both resetting to 4.
  
  `txDmaReq` is high while global, DMA and transmit enables are set and transmit occupancy is at or below its threshold. `rxDmaReq` is high while global, DMA and receive enables are set and receive occupancy is at or above its threshold.
- R7: Event bit 0 sets in the cycle after the transmit threshold condition (global and transmit enable set, occupancy at or below threshold) becomes true. Event bit 4 does the same for the receive condition.
- R8: A one-cycle pulse on `txFault` sets event bit 3; one on `rxFault` sets event bit 7.
- R9: The event register is read at index 1. Writing index 1 clears each bit written as 1 and leaves bits written as 0. An event arriving in the same cycle as its clear leaves the bit set.
- R10: `irq` is high exactly when some event bit and the same bit of the mask register (index 2, bits 7:0, reset 0) are both set.
- R11: Index 3 reads the transmit level in bits 3:0 and the receive level in bits 7:4, each saturating at 15. Writes to index 3 have no effect.
- R12: After reset, and after any write to index 0 with bit 31 clear, index 0 reads 0x00004040 and the mask reads zero.
- R13: Reads of index 4 return zero and do not change the transmit queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Bus write strobe |
| regRdEn | input | 1 | Bus read strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Bus write data |
| regRdData | output | 32 | Bus read data, valid while regRdEn is high |
| txPull | input | 1 | Engine takes the transmit head word |
| txSample | output | 32 | Transmit head word, zero when empty |
| txFault | input | 1 | Transmit fault pulse |
| rxPush | input | 1 | Engine delivers a receive word |
| rxSample | input | 32 | Receive word from the engine |
| rxFault | input | 1 | Receive fault pulse |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| irq | output | 1 | Masked event interrupt |

## Verification
The clear-by-writing-one path and the event-setting path can act on the same event bit in one clock. The bench sets up that collision in two steps:
- it first sets the transmit underrun bit by pulling from an empty transmit queue;
- it then, in one clock, writes a clear for that bit and pulls from the empty queue again.

The bit must read back as set. A following clear issued alone must then empty it, which shows the earlier result came from the collision and not from a broken clear.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int WORD_W = 32;

  // Register word indices
  localparam logic [2:0] IDX_CFG  = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_IEN  = 3'd2;
  localparam logic [2:0] IDX_LVL  = 3'd3;
  localparam logic [2:0] IDX_TXD  = 3'd4;
  localparam logic [2:0] IDX_RXD  = 3'd5;

  localparam logic [WORD_W-1:0] CFG_DEFAULT = 32'h0000_4040;
  localparam logic [3:0] THR_DEFAULT = 4'd4;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
  } fifoStb_t;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int W = 32,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/afifo_dp.sv
module afifo_dp
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [WORD_W-1:0] busWord,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] txHead,
  output logic [WORD_W-1:0] rxHead,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount
);
  afifo_store #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .wrEn(stb.txWr), .rdEn(stb.txRd),
    .wrData(busWord), .headData(txHead), .count(txCount)
  );

  afifo_store #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .wrEn(stb.rxWr), .rdEn(stb.rxRd),
    .wrData(rxWord), .headData(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              txPull,
  input  logic              txFault,
  input  logic              rxPush,
  input  logic              rxFault,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [WORD_W-1:0] txHead,
  input  logic [WORD_W-1:0] rxHead,
  output fifoStb_t          stb,
  output logic [WORD_W-1:0] txSample,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic [7:0]        stat,
  output logic [7:0]        ienMask
);
  logic gEn, dmaEn, txEn, rxEn;
  logic [3:0] txThr, rxThr;
  logic txHitQ, rxHitQ;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txHit, rxHit;
  logic wrCfg, wrStat, wrIen, wrTxd, rdRxd;
  logic [7:0] events, clrMask;
  logic [3:0] txLvl, rxLvl;
  logic unusedWrBits;

  assign unusedWrBits = ^{regWrData[29:25], regWrData[23:21], regWrData[19:16],
                          regWrData[11:8]};

  assign txFull  = (txCount == CW'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == CW'(DEPTH));
  assign rxEmpty = (rxCount == '0);

  assign wrCfg  = regWrEn && (regAddr == IDX_CFG);
  assign wrStat = regWrEn && (regAddr == IDX_STAT);
  assign wrIen  = regWrEn && (regAddr == IDX_IEN);
  assign wrTxd  = regWrEn && (regAddr == IDX_TXD);
  assign rdRxd  = regRdEn && (regAddr == IDX_RXD);

  always_comb begin
    stb.txWr = wrTxd && !txFull;
    stb.txRd = txPull && !txEmpty;
    stb.rxWr = rxPush && !rxFull;
    stb.rxRd = rdRxd && !rxEmpty;
  end

  assign txHit = gEn && txEn && (txCount <= CW'(txThr));
  assign rxHit = gEn && rxEn && (rxCount >= CW'(rxThr));
  assign txDmaReq = txHit && dmaEn;
  assign rxDmaReq = rxHit && dmaEn;

  always_comb begin
    events[0] = txHit && !txHitQ;
    events[1] = txPull && txEmpty;
    events[2] = wrTxd && txFull;
    events[3] = txFault;
    events[4] = rxHit && !rxHitQ;
    events[5] = rdRxd && rxEmpty;
    events[6] = rxPush && rxFull;
    events[7] = rxFault;
  end

  assign clrMask = wrStat ? regWrData[7:0] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEn <= 1'b0; dmaEn <= 1'b0; txEn <= 1'b0; rxEn <= 1'b0;
      txThr <= THR_DEFAULT; rxThr <= THR_DEFAULT;
      ienMask <= '0;
      stat <= '0;
      txHitQ <= 1'b0; rxHitQ <= 1'b0;
    end else begin
      if (wrCfg) begin
        if (regWrData[31]) begin
          gEn <= 1'b1; dmaEn <= regWrData[30];
          txEn <= regWrData[24]; rxEn <= regWrData[20];
          rxThr <= regWrData[15:12]; txThr <= regWrData[7:4];
        end else begin
          gEn <= 1'b0; dmaEn <= 1'b0; txEn <= 1'b0; rxEn <= 1'b0;
          txThr <= THR_DEFAULT; rxThr <= THR_DEFAULT;
          ienMask <= '0;
        end
      end
      if (wrIen) ienMask <= regWrData[7:0];
      stat <= (stat & ~clrMask) | events;
      txHitQ <= txHit;
      rxHitQ <= rxHit;
    end
  end

  assign txLvl = (txCount > CW'(15)) ? 4'hF : txCount[3:0];
  assign rxLvl = (rxCount > CW'(15)) ? 4'hF : rxCount[3:0];

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      IDX_CFG: begin
        regRdData[31] = gEn; regRdData[30] = dmaEn;
        regRdData[24] = txEn; regRdData[20] = rxEn;
        regRdData[15:12] = rxThr; regRdData[7:4] = txThr;
      end
      IDX_STAT: regRdData[7:0] = stat;
      IDX_IEN:  regRdData[7:0] = ienMask;
      IDX_LVL:  regRdData[7:0] = {rxLvl, txLvl};
      IDX_RXD:  regRdData = rxEmpty ? '0 : rxHead;
      default:  regRdData = '0;
    endcase
  end

  assign txSample = txEmpty ? '0 : txHead;
endmodule

// File: rtl/afifo_top.sv
module afifo_top
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              txPull,
  output logic [WORD_W-1:0] txSample,
  input  logic              txFault,
  input  logic              rxPush,
  input  logic [WORD_W-1:0] rxSample,
  input  logic              rxFault,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStb_t          stb;
  logic [CW-1:0]     txCount, rxCount;
  logic [WORD_W-1:0] txHead, rxHead;
  logic [7:0]        stat, ienMask;

  afifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txPull(txPull), .txFault(txFault), .rxPush(rxPush), .rxFault(rxFault),
    .txCount(txCount), .rxCount(rxCount), .txHead(txHead), .rxHead(rxHead),
    .stb(stb), .txSample(txSample), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .stat(stat), .ienMask(ienMask)
  );

  afifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWord(regWrData), .rxWord(rxSample),
    .txHead(txHead), .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount)
  );

  assign irq = |(stat & ienMask);
endmodule

// File: rtl/afifo_top_chk.sv
module afifo_top_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic          regRdEn,
  input logic [2:0]    regAddr,
  input logic [31:0]   regWrData,
  input logic [31:0]   regRdData,
  input logic          txPull,
  input logic [31:0]   txSample,
  input logic          txDmaReq,
  input logic          rxDmaReq,
  input logic          irq,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic [7:0]    stat,
  input logic [7:0]    ienMask
);
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  a_r2_tx_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd4 && txCount == CW'(DEPTH)) |=> stat[2]);

  a_r3_tx_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (txPull && txCount == '0) |-> (txSample == '0) ##1 stat[1]);

  a_r5_rx_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 3'd5 && rxCount == '0) |-> (regRdData == '0) ##1 stat[5]);

  a_r9_sticky_events: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 3'd1) |=> ((stat & $past(stat)) == $past(stat)));

  a_r10_masked_irq: assert property (@(posedge clk) disable iff (!rstN)
    (ienMask == 8'h00) |-> !irq);

  a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0 && !regWrData[31]) |=>
      (ienMask == 8'h00 && !txDmaReq && !rxDmaReq));
endmodule

bind afifo_top afifo_top_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .txPull(txPull), .txSample(txSample), .txDmaReq(txDmaReq),
  .rxDmaReq(rxDmaReq), .irq(irq), .txCount(txCount), .rxCount(rxCount),
  .stat(stat), .ienMask(ienMask)
);

// File: tb/tb_afifo_top.sv
`timescale 1ns/1ps
module tb_afifo_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0, txPull = 0, txFault = 0, rxPush = 0, rxFault = 0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0, rxSample = '0;
  logic [31:0] regRdData, txSample;
  logic txDmaReq, rxDmaReq, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  afifo_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txPull(txPull), .txSample(txSample), .txFault(txFault),
    .rxPush(rxPush), .rxSample(rxSample), .rxFault(rxFault),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; regWrEn = 0; regRdEn = 0; txPull = 0; rxPush = 0;
    txFault = 0; rxFault = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(posedge clk); #1 regWrEn = 0;
    @(posedge clk); #1;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1;
    #1 d = regRdData;
    @(posedge clk); #1 regRdEn = 0;
    @(posedge clk); #1;
  endtask

  task automatic pull(output logic [31:0] d);
    @(negedge clk);
    txPull = 1;
    #1 d = txSample;
    @(posedge clk); #1 txPull = 0;
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    rxSample = d; rxPush = 1;
    @(posedge clk); #1 rxPush = 0;
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    logic [31:0] d;
    doReset();
    busRd(3'd0, d); chk("R12 cfg reset", d, 32'h0000_4040);
    busRd(3'd1, d); chk("R9 status reset", d, 32'h0);
    busRd(3'd2, d); chk("R12 mask reset", d, 32'h0);
    busRd(3'd3, d); chk("R11 level reset", d, 32'h0);
    chk("R10 irq reset", {31'b0, irq}, 32'h0);
    chk("R6 dma reset", {30'b0, txDmaReq, rxDmaReq}, 32'h0);
  endtask

  task automatic testTxThreshold();
    logic [31:0] d;
    doReset();
    busWr(3'd0, 32'hC100_4040);
    chk("R6 tx req empty", {31'b0, txDmaReq}, 32'h1);
    busRd(3'd1, d); chk("R7 tx threshold event", d, 32'h01);
    busWr(3'd1, 32'h01);
    busRd(3'd1, d); chk("R9 clear tx thr", d, 32'h00);
    for (int i = 0; i < 5; i++) busWr(3'd4, 32'hA0 + i);
    chk("R6 tx req above thr", {31'b0, txDmaReq}, 32'h0);
    busRd(3'd3, d); chk("R11 tx level 5", d, 32'h05);
    pull(d); chk("R1 tx order 0", d, 32'hA0);
    chk("R6 tx req at thr", {31'b0, txDmaReq}, 32'h1);
    busRd(3'd1, d); chk("R7 tx event re-armed", d, 32'h01);
    for (int i = 1; i < 5; i++) begin
      pull(d); chk("R1 tx order", d, 32'hA0 + i);
    end
  endtask

  task automatic testTxOverrun();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < 33; i++) busWr(3'd4, 32'h100 + i);
    busRd(3'd3, d); chk("R11 tx level saturates", d, 32'h0F);
    busRd(3'd1, d); chk("R2 tx overrun bit", d, 32'h04);
    busRd(3'd4, d); chk("R13 tx port reads zero", d, 32'h0);
    for (int i = 0; i < 32; i++) begin
      pull(d); chk("R1 R2 tx data kept", d, 32'h100 + i);
    end
    pull(d); chk("R3 empty pull zero", d, 32'h0);
    busRd(3'd1, d); chk("R3 tx underrun bit", d, 32'h06);
  endtask

  task automatic testRx();
    logic [31:0] d;
    doReset();
    busWr(3'd0, 32'hC010_2040);
    busRd(3'd0, d); chk("R6 cfg readback", d, 32'hC010_2040);
    push(32'h55);
    chk("R6 rx req below thr", {31'b0, rxDmaReq}, 32'h0);
    push(32'h66);
    chk("R6 rx req at thr", {31'b0, rxDmaReq}, 32'h1);
    busRd(3'd1, d); chk("R7 rx threshold event", d, 32'h10);
    busRd(3'd5, d); chk("R1 rx order 0", d, 32'h55);
    busRd(3'd5, d); chk("R1 rx order 1", d, 32'h66);
    busRd(3'd5, d); chk("R5 rx empty read", d, 32'h0);
    busRd(3'd1, d); chk("R5 rx underrun bit", d, 32'h30);
    for (int i = 0; i < 33; i++) push(32'h200 + i);
    busRd(3'd1, d); chk("R4 rx overrun bit", d, 32'h70);
    busRd(3'd3, d); chk("R11 rx level saturates", d, 32'hF0);
    for (int i = 0; i < 32; i++) begin
      busRd(3'd5, d); chk("R1 R4 rx data kept", d, 32'h200 + i);
    end
  endtask

  task automatic testFaultIrq();
    logic [31:0] d;
    doReset();
    @(negedge clk); txFault = 1; @(negedge clk); txFault = 0;
    busRd(3'd1, d); chk("R8 tx fault", d, 32'h08);
    @(negedge clk); rxFault = 1; @(negedge clk); rxFault = 0;
    busRd(3'd1, d); chk("R8 rx fault", d, 32'h88);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    busWr(3'd2, 32'h80);
    chk("R10 irq enabled", {31'b0, irq}, 32'h1);
    busWr(3'd1, 32'h00);
    busRd(3'd1, d); chk("R9 zero write keeps", d, 32'h88);
    busWr(3'd1, 32'h80);
    busRd(3'd1, d); chk("R9 one clears one", d, 32'h08);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    doReset();
    pull(d);
    busRd(3'd1, d); chk("R3 underrun set", d, 32'h02);
    @(negedge clk);
    regAddr = 3'd1; regWrData = 32'h02; regWrEn = 1; txPull = 1;
    @(posedge clk); #1 regWrEn = 0; txPull = 0;
    busRd(3'd1, d); chk("R9 set wins over clear", d, 32'h02);
    busWr(3'd1, 32'h02);
    busRd(3'd1, d); chk("R9 lone clear", d, 32'h00);
  endtask

  task automatic testDisable();
    logic [31:0] d;
    doReset();
    busWr(3'd2, 32'hFF);
    busWr(3'd0, 32'hC110_4040);
    chk("R6 tx req enabled", {31'b0, txDmaReq}, 32'h1);
    busWr(3'd4, 32'h77);
    busWr(3'd3, 32'hFFFF);
    busRd(3'd3, d); chk("R11 level write ignored", d, 32'h01);
    busWr(3'd0, 32'h0000_F0F0);
    busRd(3'd0, d); chk("R12 cfg default", d, 32'h0000_4040);
    busRd(3'd2, d); chk("R12 mask cleared", d, 32'h0);
    chk("R12 dma off", {30'b0, txDmaReq, rxDmaReq}, 32'h0);
    pull(d); chk("R1 data survives disable", d, 32'h77);
  endtask

  initial begin
    testReset();
    testTxThreshold();
    testTxOverrun();
    testRx();
    testFaultIrq();
    testCollision();
    testDisable();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule